// File: doc/BRIEF.md
# Video Temporal Field and Frame Decimator

This block sits in a video capture path between the decoder front end and the engine that bursts pixels onto the system bus. At every field-start strobe it decides whether the coming field is forwarded or discarded. Discarded fields hold both the pixel-valid output and the active indicator low for their whole length. A programmable drop count sets how many units are discarded in each repeating cadence window. The window is 60 fields on the 525-line standard and 50 fields on the 625-line standard.

In field mode each field is one unit. In frame mode an odd field and the even field after it form one unit. The window then counts 30 or 25 frames, and both fields of a frame share one decision. An accumulator spreads the drops evenly across the window. Settings written mid-window wait for the next window start. Each discarded field start yields a one-cycle pulse, so software can tell intended drops apart from losses on the bus.

Top module: `videoTdec`

## Requirements
- R1: After reset, activeOut, outValid and dropPulse are low, and the cadence window starts at unit position 0.
- R2: In field mode (frameMode=0) with effective count c and window W (60 when lineStd=0, 50 when lineStd=1), the unit at 1-based window position k is dropped exactly when floor(k*c/W) > floor((k-1)*c/W). That gives c drops per window, evenly spread.
- R3: A count of 0 disables decimation, so every field is kept.
- R4: In frame mode (frameMode=1) the window is 30 frames (lineStd=0) or 25 frames (lineStd=1). A unit starts at a field start with fieldOdd=1, and the even field that follows takes the same keep/drop decision, so a frame is never split.
- R5: From the cycle after a dropped field's strobe until the next strobe, activeOut and outValid stay low whatever pixValid does.
- R6: From the cycle after a kept field's strobe, activeOut is high and outValid equals pixValid in the same cycle.
- R7: dropPulse is high for exactly the one cycle after the strobe of each discarded field, and low otherwise.
- R8: A change of decCount or frameMode takes effect only at the first unit of the next window (position 0). Units later in the current window use the values latched at its start.
- R9: A cycle with softRst high returns the window to position 0.
- R10: A change of lineStd returns the window to position 0.
- R11: A count above the window length is clamped to it, so every unit is dropped.
- R12: In frame mode, an even field with no preceding odd field inherits the last odd-field decision. After reset, that decision is keep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| softRst | input | 1 | Synchronous window restart |
| lineStd | input | 1 | 0: 525-line (60 fields), 1: 625-line (50 fields) |
| frameMode | input | 1 | 0: per-field decimation, 1: per-frame decimation |
| decCount | input | 6 | Units to drop per window, 0 disables |
| fieldStart | input | 1 | One-cycle strobe at the start of each field |
| fieldOdd | input | 1 | Parity of the field starting, 1 = odd |
| pixValid | input | 1 | Pixel qualifier from the front end |
| outValid | output | 1 | Gated pixel qualifier |
| activeOut | output | 1 | High while the current field is forwarded |
| dropPulse | output | 1 | One-cycle pulse per discarded field start |

## Verification
The keep/drop decision for a field is registered at the strobe's edge. activeOut and dropPulse are therefore sampled at the falling edge one half-cycle after that rising edge. outValid is combinational from pixValid and the registered decision, so it is checked a moment after pixValid is driven, with no extra clock. dropPulse is checked again one cycle later, where it must be low. A reference model updated once per strobe supplies every expected value, using the closed-form drop rule of R2 and the window, latching and inheritance rules.

// File: rtl/video_tdec_pkg.sv
package video_tdec_pkg;
  typedef struct packed {
    logic unitStart;   // a new field or frame unit begins
    logic dropNow;     // the beginning unit is discarded
    logic inherit;     // even field follows the last frame decision
  } tdecStrobes_t;
endpackage

// File: rtl/tdecCadenceCtl.sv
module tdecCadenceCtl
  import video_tdec_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int FIELDS_525 = 60,
  parameter int FIELDS_625 = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             lineStd,
  input  logic             frameMode,
  input  logic [CNT_W-1:0] decCount,
  input  logic             fieldStart,
  input  logic             fieldOdd,
  output tdecStrobes_t     strobes
);
  localparam int MAXW  = (FIELDS_525 > FIELDS_625) ? FIELDS_525 : FIELDS_625;
  localparam int POS_W = $clog2(MAXW);
  localparam int CW    = ((CNT_W > POS_W) ? CNT_W : POS_W) + 1;
  localparam logic [CW-1:0] WF0 = CW'(FIELDS_525);
  localparam logic [CW-1:0] WF1 = CW'(FIELDS_625);
  localparam logic [CW-1:0] WR0 = CW'(FIELDS_525 / 2);
  localparam logic [CW-1:0] WR1 = CW'(FIELDS_625 / 2);

  logic [POS_W-1:0] posQ, accQ, effPos, effAcc;
  logic [CNT_W-1:0] cntQ, cntSel;
  logic             modeQ, modeSel, stdQ, stdChange, isUnit, dropUnit, winStart;
  logic [CW-1:0]    winLen, cntClamp, sum;

  assign stdChange = (lineStd != stdQ);
  assign effPos    = stdChange ? '0 : posQ;
  assign effAcc    = stdChange ? '0 : accQ;
  assign winStart  = (effPos == '0);
  assign modeSel   = winStart ? frameMode : modeQ;
  assign cntSel    = winStart ? decCount  : cntQ;

  always_comb begin
    unique case ({modeSel, lineStd})
      2'b00:   winLen = WF0;
      2'b01:   winLen = WF1;
      2'b10:   winLen = WR0;
      default: winLen = WR1;
    endcase
  end

  assign cntClamp = (CW'(cntSel) > winLen) ? winLen : CW'(cntSel);
  assign sum      = CW'(effAcc) + cntClamp;
  assign dropUnit = (sum >= winLen);
  assign isUnit   = fieldStart & ~softRst & (~modeSel | fieldOdd);

  assign strobes.unitStart = isUnit;
  assign strobes.dropNow   = dropUnit;
  assign strobes.inherit   = fieldStart & ~softRst & modeSel & ~fieldOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ  <= '0;
      accQ  <= '0;
      cntQ  <= '0;
      modeQ <= 1'b0;
      stdQ  <= 1'b0;
    end else begin
      stdQ <= lineStd;
      if (softRst) begin
        posQ <= '0;
        accQ <= '0;
      end else if (isUnit) begin
        accQ <= dropUnit ? POS_W'(sum - winLen) : POS_W'(sum);
        posQ <= (CW'(effPos) == winLen - 1'b1) ? '0 : effPos + 1'b1;
        if (winStart) begin
          cntQ  <= decCount;
          modeQ <= frameMode;
        end
      end else if (stdChange) begin
        posQ <= '0;
        accQ <= '0;
      end
    end
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (posQ < POS_W'(FIELDS_525)) && (posQ < POS_W'(MAXW)));
  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    CW'(accQ) < CW'(MAXW));
  // R3
  zero_count_no_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isUnit && cntSel == '0) |-> !dropUnit);
  // R9
  soft_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (posQ == '0 && accQ == '0));
endmodule

// File: rtl/tdecGateDp.sv
module tdecGateDp
  import video_tdec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  tdecStrobes_t strobes,
  input  logic         pixValid,
  output logic         outValid,
  output logic         activeOut,
  output logic         dropPulse
);
  logic keepQ, lastKeepQ, pulseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepQ     <= 1'b0;
      lastKeepQ <= 1'b1;
      pulseQ    <= 1'b0;
    end else begin
      pulseQ <= 1'b0;
      if (strobes.unitStart) begin
        keepQ     <= ~strobes.dropNow;
        lastKeepQ <= ~strobes.dropNow;
        pulseQ    <= strobes.dropNow;
      end else if (strobes.inherit) begin
        keepQ  <= lastKeepQ;
        pulseQ <= ~lastKeepQ;
      end
    end
  end

  assign outValid  = pixValid & keepQ;
  assign activeOut = keepQ;
  assign dropPulse = pulseQ;

  // R7
  pulse_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    dropPulse |-> !activeOut);
  // R5
  gated_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (activeOut && pixValid));
  // R4
  frame_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inherit |=> (activeOut == $past(lastKeepQ)));
endmodule

// File: rtl/videoTdec.sv
module videoTdec
  import video_tdec_pkg::*;
#(
  parameter int CNT_W      = 6,
  parameter int FIELDS_525 = 60,
  parameter int FIELDS_625 = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             lineStd,
  input  logic             frameMode,
  input  logic [CNT_W-1:0] decCount,
  input  logic             fieldStart,
  input  logic             fieldOdd,
  input  logic             pixValid,
  output logic             outValid,
  output logic             activeOut,
  output logic             dropPulse
);
  tdecStrobes_t strobes;

  tdecCadenceCtl #(
    .CNT_W(CNT_W), .FIELDS_525(FIELDS_525), .FIELDS_625(FIELDS_625)
  ) i_ctl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .lineStd(lineStd),
    .frameMode(frameMode), .decCount(decCount), .fieldStart(fieldStart),
    .fieldOdd(fieldOdd), .strobes(strobes)
  );

  tdecGateDp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pixValid(pixValid),
    .outValid(outValid), .activeOut(activeOut), .dropPulse(dropPulse)
  );
endmodule

// File: tb/test_videoTdec.sv
module test_videoTdec;
  logic clk = 1'b0, rstN = 1'b0, softRst = 1'b0, lineStd = 1'b0, frameMode = 1'b0;
  logic [5:0] decCount = '0;
  logic fieldStart = 1'b0, fieldOdd = 1'b0, pixValid = 1'b0;
  logic outValid, activeOut, dropPulse;
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int mPos = 0, mCnt = 0;
  bit mMode = 0, mLast = 1, mKeep = 0;

  always #2 clk = ~clk;

  videoTdec i_videoTdec (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int winLen(bit frm, bit std);
    return frm ? (std ? 25 : 30) : (std ? 50 : 60);
  endfunction

  function automatic bit dropAt(int k, int c, int w);
    return ((k * c) / w) > (((k - 1) * c) / w);
  endfunction

  // model update for one field start; returns expected drop
  function automatic bit modelField(bit odd);
    bit ms, dr;
    int cs, w, c;
    ms = (mPos == 0) ? frameMode : mMode;
    cs = (mPos == 0) ? int'(decCount) : mCnt;
    if (!ms || odd) begin
      if (mPos == 0) begin mMode = frameMode; mCnt = int'(decCount); end
      w  = winLen(ms, lineStd);
      c  = (cs > w) ? w : cs;
      dr = dropAt(mPos + 1, c, w);
      mPos  = (mPos + 1 == w) ? 0 : mPos + 1;
      mLast = !dr;
      mKeep = !dr;
    end else begin
      mKeep = mLast;
      dr    = !mLast;
    end
    return dr;
  endfunction

  // one field: strobe, then a few pixel cycles checked
  task automatic runField(bit odd, string req, int pixCycles);
    bit expDrop;
    @(negedge clk);
    fieldStart = 1'b1; fieldOdd = odd; pixValid = 1'b0;
    expDrop = modelField(odd);
    @(negedge clk);
    fieldStart = 1'b0;
    chk({req, " R7 pulse"}, dropPulse, expDrop);
    chk({req, " R5/R6 active"}, activeOut, mKeep);
    for (int i = 0; i < pixCycles; i++) begin
      pixValid = $urandom_range(0, 1);
      #1;
      chk(mKeep ? "R6 outValid" : "R5 outValid", outValid, pixValid & mKeep);
      @(negedge clk);
      if (i == 0) chk("R7 single", dropPulse, 0);
    end
    pixValid = 1'b0;
  endtask

  task automatic doSoftRst();
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
    mPos = 0;
  endtask

  task automatic setStd(bit s);
    @(negedge clk); lineStd = s;
    @(negedge clk);
    mPos = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 active", activeOut, 0);
    chk("R1 pulse", dropPulse, 0);
    pixValid = 1'b1; #1;
    chk("R1 outValid", outValid, 0);
    pixValid = 1'b0;
    rstN = 1'b1;

    // R12: frame mode even field first inherits keep
    frameMode = 1'b1; decCount = 6'd10;
    runField(1'b0, "R12", 2);

    // R3: count 0 passes all fields
    doSoftRst();
    frameMode = 1'b0; decCount = 6'd0;
    for (int i = 0; i < 60; i++) runField(i[0], "R3", 1);

    // R2: 525 field mode, count 20, a full window
    doSoftRst();
    decCount = 6'd20;
    for (int i = 0; i < 60; i++) runField(i[0], "R2", 1);

    // R8: mid-window change waits for window start
    for (int i = 0; i < 10; i++) runField(i[0], "R2", 1);
    decCount = 6'd45;
    for (int i = 0; i < 55; i++) runField(i[0], "R8", 1);

    // R10: standard change restarts window, 625 field mode
    setStd(1'b1);
    decCount = 6'd7;
    for (int i = 0; i < 50; i++) runField(i[0], "R10", 1);

    // R11: count above window clamps, all dropped
    doSoftRst();
    decCount = 6'd60;
    for (int i = 0; i < 8; i++) runField(i[0], "R11", 1);

    // R4: frame mode 625, count 5 frames
    doSoftRst();
    frameMode = 1'b1; decCount = 6'd5;
    for (int i = 0; i < 50; i++) runField(!i[0], "R4", 1);

    // R9: soft reset mid-window
    for (int i = 0; i < 7; i++) runField(!i[0], "R4", 1);
    doSoftRst();
    for (int i = 0; i < 10; i++) runField(!i[0], "R9", 1);

    // random mix
    setStd(1'b0);
    doSoftRst();
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0) decCount = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 30) == 0) frameMode = ~frameMode;
      if ($urandom_range(0, 80) == 0) setStd(~lineStd);
      if ($urandom_range(0, 90) == 0) doSoftRst();
      runField($urandom_range(0, 3) != 0 ? i[0] : 1'($urandom_range(0, 1)), "R2 rnd", 1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule